// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves a data word between two buses, A and B, in both directions at once. Each direction has its own storage stage with a latch enable, a strobe and an output enable. While the latch enable is high the stage is transparent, so the destination follows the source in the same cycle. While it is low the stage keeps its stored word until a rising strobe edge loads a new one. The strobe is a data-rate control input. The block samples it on the system clock and acts on a 0-to-1 change between two samples.

The bidirectional pins are split into a data-in vector, a data-out vector and a per-bit drive-enable vector, so a pad ring above the block can build true three-state ports. The A-to-B enable is active high. The B-to-A enable is active low.

An optional bus-hold stage sits on each data input, selected by the parameter `HOLD_EN`, which is on by default. It remembers the last word seen while the matching valid qualifier was high. While the qualifier is low, that remembered word stands in for the live input on both the transparent path and the capture path.

An asynchronous active-low reset clears all state. The reset is released synchronously inside the block.

Top module: `regxcvr`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals the effective A input in the same cycle, whatever the level or edges of `ab_ck`.
- R2: While `ab_le` is 0 and no rising `ab_ck` edge has been sampled, `b_out` keeps its previous value.
- R3: While `ab_le` is 0, a rising `ab_ck` edge loads the effective A input into the stage. A rising edge is `ab_ck` 0 at one clock edge and 1 at the next. The loaded word appears on `b_out` from the following cycle on.
- R4: `b_oe` is all ones when `ab_oe` is 1 and all zeros when `ab_oe` is 0. The enable does not change the stored word or the value on `b_out`.
- R5: The B-to-A path behaves like A-to-B under R1 to R3, using `ba_le` and `ba_ck` and driving `a_out` from the effective B input. `a_oe` is all ones when `ba_oe_n` is 0 and all zeros when `ba_oe_n` is 1.
- R6: When the latch enable falls, the output keeps the word it showed at the last clock edge with the enable high. This holds whatever the strobe level, including a strobe that is already high, until the next rising strobe edge.
- R7: With bus hold enabled, the effective input of a side is its live input while its valid qualifier (`a_vld` or `b_vld`) is 1. While the qualifier is 0, the effective input is the last word sampled at a clock edge with the qualifier at 1, and this applies to both the transparent and the captured paths.
- R8: After reset both stages, both hold registers and both strobe detectors are 0. With both latch enables low, `a_out` and `b_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | A-side data seen at the pins |
| a_vld | input | 1 | A-side input driven (qualifier for bus hold) |
| b_in | input | W | B-side data seen at the pins |
| b_vld | input | 1 | B-side input driven (qualifier for bus hold) |
| ab_le | input | 1 | A-to-B latch enable, high for transparent |
| ab_ck | input | 1 | A-to-B capture strobe |
| ab_oe | input | 1 | B-side drive enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high for transparent |
| ba_ck | input | 1 | B-to-A capture strobe |
| ba_oe_n | input | 1 | A-side drive enable, active low |
| a_out | output | W | Data driven toward the A side |
| a_oe | output | W | Per-bit drive enable for the A side |
| b_out | output | W | Data driven toward the B side |
| b_oe | output | W | Per-bit drive enable for the B side |

## Verification
Random words are driven in both directions with each latch enable mostly low, strobes toggling at random, and the valid qualifiers dropping now and then. This tells transparent following apart from holding and from capture on a sampled rising strobe. A directed run raises the strobe during transparency and then drops the latch enable with the strobe still high. That shows the output keeps the last transparent word and that the earlier edge left nothing of its own. Sweeping both enable polarities separates the drive-enable vectors from the data, and runs with the qualifier low show the remembered word replacing the live input on both paths.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic le;
    logic ck;
    logic oe;
  } dir_ctrl_t;
endpackage

// File: rtl/regxcvr_rst_sync.sv
module regxcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/regxcvr_hold.sv
module regxcvr_hold #(
  parameter int unsigned W       = 18,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         vld,
  output logic [W-1:0] eff
);
  generate
    if (HOLD_EN) begin : g_hold
      logic [W-1:0] hold_q;
      logic [W-1:0] hold_d;
      logic         hold_en;

      always_comb begin
        hold_en = vld;
        hold_d  = din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (hold_en) hold_q <= hold_d;
      end

      assign eff = vld ? din : hold_q;
    end else begin : g_pass
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, vld};
      assign eff = din;
    end
  endgenerate
endmodule

// File: rtl/regxcvr_path.sv
module regxcvr_path
  import regxcvr_pkg::*;
#(
  parameter int unsigned W      = 18,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  dir_ctrl_t    ctl,
  output logic [W-1:0] q,
  output logic [W-1:0] q_oe
);
  logic         ck_q;
  logic         rise;
  logic         st_en;
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;
  logic         drive;

  always_comb begin
    rise  = ctl.ck & ~ck_q;
    st_en = ctl.le | rise;
    st_d  = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= 1'b0;
    else        ck_q <= ctl.ck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign q = ctl.le ? d : st_q;

  generate
    if (OE_LOW) begin : g_oe_low
      assign drive = ~ctl.oe;
    end else begin : g_oe_high
      assign drive = ctl.oe;
    end
  endgenerate

  assign q_oe = {W{drive}};
endmodule

// File: rtl/regxcvr.sv
module regxcvr
  import regxcvr_pkg::*;
#(
  parameter int unsigned W       = 18,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_vld,
  input  logic [W-1:0] b_in,
  input  logic         b_vld,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_ck,
  input  logic         ba_oe_n,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic         rst_n_s;
  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;
  dir_ctrl_t    ab_ctl;
  dir_ctrl_t    ba_ctl;

  assign ab_ctl = '{le: ab_le, ck: ab_ck, oe: ab_oe};
  assign ba_ctl = '{le: ba_le, ck: ba_ck, oe: ba_oe_n};

  regxcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  regxcvr_hold #(.W(W), .HOLD_EN(HOLD_EN)) u_hold_a (
    .clk(clk), .rst_n(rst_n_s), .din(a_in), .vld(a_vld), .eff(a_eff)
  );

  regxcvr_hold #(.W(W), .HOLD_EN(HOLD_EN)) u_hold_b (
    .clk(clk), .rst_n(rst_n_s), .din(b_in), .vld(b_vld), .eff(b_eff)
  );

  regxcvr_path #(.W(W), .OE_LOW(1'b0)) u_ab (
    .clk(clk), .rst_n(rst_n_s), .d(a_eff), .ctl(ab_ctl),
    .q(b_out), .q_oe(b_oe)
  );

  regxcvr_path #(.W(W), .OE_LOW(1'b1)) u_ba (
    .clk(clk), .rst_n(rst_n_s), .d(b_eff), .ctl(ba_ctl),
    .q(a_out), .q_oe(a_oe)
  );
endmodule

// File: rtl/regxcvr_chk.sv
module regxcvr_chk #(
  parameter int unsigned W       = 18,
  parameter bit          HOLD_EN = 1'b1
) (
  input logic         clk,
  input logic         rst_n_s,
  input logic         a_vld,
  input logic         b_vld,
  input logic         ab_le,
  input logic         ab_ck,
  input logic         ab_oe,
  input logic         ba_le,
  input logic         ba_ck,
  input logic         ba_oe_n,
  input logic [W-1:0] a_eff,
  input logic [W-1:0] b_eff,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe
);
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ab_le && !$rose(ab_ck)) |=> (ab_le || $stable(b_out))); // R2

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ab_le && $rose(ab_ck)) |=> (ab_le || b_out == $past(a_eff))); // R3

  AST_AB_OE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ab_oe ? (&b_oe) : (b_oe == '0)); // R4

  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ba_le && !$rose(ba_ck)) |=> (ba_le || $stable(a_out))); // R5

  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ba_le && $rose(ba_ck)) |=> (ba_le || a_out == $past(b_eff))); // R5

  AST_BA_OE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ba_oe_n ? (a_oe == '0) : (&a_oe)); // R5

  AST_LE_FALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ab_le ##1 (!ab_le && !$rose(ab_ck))) |-> (b_out == $past(a_eff))); // R6

  generate
    if (HOLD_EN) begin : g_hold_chk
      AST_A_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
        (!a_vld && $past(!a_vld)) |-> $stable(a_eff)); // R7

      AST_B_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
        (!b_vld && $past(!b_vld)) |-> $stable(b_eff)); // R7
    end
  endgenerate
endmodule

bind regxcvr regxcvr_chk #(.W(W), .HOLD_EN(HOLD_EN)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .a_vld(a_vld), .b_vld(b_vld),
  .ab_le(ab_le), .ab_ck(ab_ck), .ab_oe(ab_oe),
  .ba_le(ba_le), .ba_ck(ba_ck), .ba_oe_n(ba_oe_n),
  .a_eff(a_eff), .b_eff(b_eff), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe)
);

// File: tb/tb_regxcvr.sv
module tb_regxcvr;
  localparam int unsigned W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         a_vld = 1'b0, b_vld = 1'b0;
  logic         ab_le = 1'b0, ab_ck = 1'b0, ab_oe = 1'b0;
  logic         ba_le = 1'b0, ba_ck = 1'b0, ba_oe_n = 1'b1;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int total = 0;
  int bad = 0;

  // model state
  logic [W-1:0] m_hold_a = '0, m_hold_b = '0, m_st_ab = '0, m_st_ba = '0;
  logic         m_ckq_ab = 1'b0, m_ckq_ba = 1'b0;
  logic         cap_ab = 1'b0, cap_ba = 1'b0;

  always #10 clk = ~clk;

  regxcvr #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_vld(a_vld), .b_in(b_in),
    .b_vld(b_vld), .ab_le(ab_le), .ab_ck(ab_ck), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_ck(ba_ck), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [W-1:0] eff_of(logic [W-1:0] d, logic v, logic [W-1:0] h);
    return v ? d : h;
  endfunction

  function automatic logic [W-1:0] out_of(logic le, logic [W-1:0] e, logic [W-1:0] st);
    return le ? e : st;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [W-1:0] ai, input logic [W-1:0] bi,
                     input logic av, input logic bv,
                     input logic abl, input logic abc, input logic abo,
                     input logic bal, input logic bac, input logic bao,
                     input string tg);
    logic [W-1:0] ea, eb, xb, xa;
    string ta, tb2;
    @(negedge clk);
    a_in = ai; b_in = bi; a_vld = av; b_vld = bv;
    ab_le = abl; ab_ck = abc; ab_oe = abo;
    ba_le = bal; ba_ck = bac; ba_oe_n = bao;
    #1;
    ea = eff_of(ai, av, m_hold_a);
    eb = eff_of(bi, bv, m_hold_b);
    xb = out_of(abl, ea, m_st_ab);
    xa = out_of(bal, eb, m_st_ba);
    ta  = abl ? (av ? "R1" : "R7") : (cap_ab ? "R3" : "R2");
    tb2 = bal ? (bv ? "R5" : "R7") : "R5";
    if (tg != "") ta = tg;
    chk(b_out == xb, ta, b_out, xb);
    chk(a_out == xa, tb2, a_out, xa);
    chk(b_oe == (abo ? {W{1'b1}} : {W{1'b0}}), "R4", b_oe, abo ? {W{1'b1}} : {W{1'b0}});
    chk(a_oe == (bao ? {W{1'b0}} : {W{1'b1}}), "R5", a_oe, bao ? {W{1'b0}} : {W{1'b1}});
    @(posedge clk);
    cap_ab = 1'b0; cap_ba = 1'b0;
    if (abl) m_st_ab = ea;
    else if (abc && !m_ckq_ab) begin m_st_ab = ea; cap_ab = 1'b1; end
    if (bal) m_st_ba = eb;
    else if (bac && !m_ckq_ba) begin m_st_ba = eb; cap_ba = 1'b1; end
    m_ckq_ab = abc; m_ckq_ba = bac;
    if (av) m_hold_a = ai;
    if (bv) m_hold_b = bi;
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(a_out == '0, "R8", a_out, '0);
    chk(b_out == '0, "R8", b_out, '0);
    chk(b_oe == '0, "R8", b_oe, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc('0, '0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");

    // R6: strobe rises while transparent, then enable falls with strobe high
    cyc(18'h1234, 18'h0aaaa, 1, 1, 1, 0, 1, 1, 0, 0, "R1");
    cyc(18'h2a5a5, 18'h15555, 1, 1, 1, 1, 1, 1, 1, 0, "R1");
    cyc(18'h3ffff, 18'h00f0f, 1, 1, 0, 1, 1, 0, 1, 0, "R6");
    cyc(18'h00001, 18'h00002, 1, 1, 0, 1, 1, 0, 1, 0, "R6");
    cyc(18'h00003, 18'h00004, 1, 1, 0, 0, 0, 0, 0, 1, "R2");
    cyc(18'h1c3c3, 18'h23c3c, 1, 1, 0, 1, 0, 0, 1, 1, "R2");
    cyc(18'h00007, 18'h00008, 1, 1, 0, 1, 1, 0, 1, 0, "R3");
    // R7: hold replaces input on capture and transparent paths
    cyc(18'h0beef, 18'h0cafe, 1, 1, 0, 0, 1, 0, 0, 0, "R2");
    cyc(18'h3aaaa, 18'h35555, 0, 0, 0, 1, 1, 0, 1, 0, "R7");
    cyc(18'h11111, 18'h22222, 0, 0, 1, 0, 1, 1, 0, 0, "R7");
    cyc(18'h11111, 18'h22222, 0, 0, 0, 0, 1, 0, 0, 0, "R7");

    for (int i = 0; i < 3000; i++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      cyc(ra, rb, ($urandom % 4) != 0, ($urandom % 4) != 0,
          ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
          ($urandom % 4) == 0, 1'($urandom), 1'($urandom), "");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule